// File: doc/BRIEF.md
# Synchronized Low-Stop Clock Gate

This block gates one group of clock outputs that are derived from a single source clock. A stop request arrives asynchronously and is active low. The block brings the request into the source clock domain through a flop chain. It then decides, on the falling edge of the source clock, whether the group runs. Because the enable only changes while the source is low, a stopped group always rests low and every high phase it produces is a whole source high phase. A separate output follows the source clock at all times and is never gated.

After every restart, the block keeps the group running for a minimum number of cycles. A stop request that arrives inside that window is held pending. It takes effect on the first falling edge after the window has elapsed. An override input, used for power-down, stops the group regardless of the hold-off window. While the override is active the stop request has no effect. Parameters set the group width, the depth of the synchronizer and the minimum enabled interval. These parameters let the same block serve a fast processor clock group with a long hold-off, or a bus clock group with short latencies and a short hold-off.

Top module: `clkstop_gate`

## Requirements
- R1: `clk_free` equals `clk_src` in every cycle, including during reset and while the override is active.
- R2: While stopped, every bit of `clk_grp` is low. All bits of `clk_grp` are identical at all times.
- R3: Every high phase seen on `clk_grp` is high across the whole high phase of `clk_src`. `clk_grp` is low during every low phase of `clk_src`.
- R4: Let `stop_n` go high, with `pd_req` low, before rising edge E1 of a stopped group. The first gated high phase then begins at rising edge E(SYNC_STAGES+1).
- R5: Let `stop_n` go low before rising edge E1 once the hold-off window has elapsed. The last gated high phase then begins at E(SYNC_STAGES), and none follows.
- R6: After each restart the group delivers at least MIN_ON high phases before a stop request or a released request can end the run, unless the override intervenes.
- R7: A stop request that is still held when the hold-off window runs out ends the run after exactly MIN_ON high phases.
- R8: Let `pd_req` go high before rising edge E1. The last gated high phase then begins at E(SYNC_STAGES), even while the hold-off window is still running.
- R9: While `pd_req` is high, toggling `stop_n` produces no high phase on `clk_grp`.
- R10: Let `pd_req` go low with `stop_n` high before E1. The group restarts at E(SYNC_STAGES+1) and the hold-off window starts again from MIN_ON.
- R11: While `rst_n` is low, `clk_grp` is low. Let `rst_n` rise before rising edge E1 with `stop_n` high. The first gated high phase then begins at E3.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock for the group and the free output |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stop_n | input | 1 | Asynchronous stop request, low = stop the group |
| pd_req | input | 1 | Asynchronous override, high = force the group stopped |
| clk_free | output | 1 | Ungated copy of the source clock |
| clk_grp | output | GROUP_W | Gated clock outputs of the group |

## Verification
The main pattern sweeps how long a run lasts before the stop request falls. Runs shorter than the hold-off window show the pending behaviour and give exactly MIN_ON phases. Longer runs show the plain turn-off latency. Every sweep point also measures the turn-on edge. Each gated high phase is sampled early and late within the phase, and each low phase is sampled as well, so any clipped or stray pulse is caught. A second pattern raises the override inside a fresh hold-off window and toggles the stop request under it. It then releases the override into a short run. This tells an override that preempts the window apart from one that waits for it, and shows whether the window is reloaded after the override.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

  // Width of a down-counter that must hold the value n-1.
  function automatic int unsigned cnt_bits(input int unsigned n);
    if (n <= 2) return 1;
    return $clog2(n);
  endfunction

endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
module clkstop_sync #(
  parameter int unsigned STAGES  = 2,
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  always_comb begin
    chain_d[0] = d;
    for (int s = 1; s < STAGES; s++) begin
      chain_d[s] = chain_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        chain_q[s] <= RST_VAL;
      end
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/clkstop_holdoff.sv
`timescale 1ns/1ps
module clkstop_holdoff #(
  parameter int unsigned MIN_ON = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_s,
  input  logic pd_s,
  output logic en_q
);

  localparam int unsigned CW = clkstop_pkg::cnt_bits(MIN_ON);
  localparam logic [CW-1:0] RELOAD = CW'(MIN_ON - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          en_d;

  // Next-state: decided for the falling edge, while the source is low.
  always_comb begin
    en_d  = en_q;
    cnt_d = cnt_q;
    if (pd_s) begin
      en_d = 1'b0;
    end else if (!en_q) begin
      if (run_s) begin
        en_d  = 1'b1;
        cnt_d = RELOAD;
      end
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else if (!run_s) begin
      en_d = 1'b0;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_q  <= en_d;
      cnt_q <= cnt_d;
    end
  end

  AST_MIN_ENABLE: assert property (@(negedge clk) disable iff (!rst_n)
    $fell(en_q) |-> $past(cnt_q == '0 || pd_s)); // R6

  AST_PD_FORCE: assert property (@(negedge clk) disable iff (!rst_n)
    pd_s |=> !en_q); // R8

  AST_START_CAUSE: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(run_s && !pd_s)); // R4

  AST_PENDING_STOP: assert property (@(negedge clk) disable iff (!rst_n)
    (en_q && cnt_q == '0 && !run_s) |=> !en_q); // R7

endmodule

// File: rtl/clkstop_gate_cell.sv
`timescale 1ns/1ps
module clkstop_gate_cell (
  input  logic clk,
  input  logic en,
  output logic gclk
);

  // en only moves on a falling edge, so the AND cannot clip a high phase.
  assign gclk = clk & en;

endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
module clkstop_gate #(
  parameter int unsigned GROUP_W     = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_ON      = 100
) (
  input  logic               clk_src,
  input  logic               rst_n,
  input  logic               stop_n,
  input  logic               pd_req,
  output logic               clk_free,
  output logic [GROUP_W-1:0] clk_grp
);

  localparam int unsigned RST_STAGES = 2;

  logic       rst_ok;
  logic [1:0] req_s;
  logic       grp_en;

  clkstop_sync #(
    .STAGES (RST_STAGES),
    .W      (1),
    .RST_VAL(1'b0)
  ) u_rst_sync (
    .clk  (clk_src),
    .rst_n(rst_n),
    .d    (1'b1),
    .q    (rst_ok)
  );

  // bit 1: override, bit 0: run request (reset to running)
  clkstop_sync #(
    .STAGES (SYNC_STAGES),
    .W      (2),
    .RST_VAL(2'b01)
  ) u_req_sync (
    .clk  (clk_src),
    .rst_n(rst_ok),
    .d    ({pd_req, stop_n}),
    .q    (req_s)
  );

  clkstop_holdoff #(
    .MIN_ON(MIN_ON)
  ) u_holdoff (
    .clk  (clk_src),
    .rst_n(rst_ok),
    .run_s(req_s[0]),
    .pd_s (req_s[1]),
    .en_q (grp_en)
  );

  generate
    for (genvar i = 0; i < GROUP_W; i++) begin : g_cell
      clkstop_gate_cell u_cell (
        .clk (clk_src),
        .en  (grp_en),
        .gclk(clk_grp[i])
      );
    end
  endgenerate

  assign clk_free = clk_src;

endmodule

// File: tb/clkstop_gate_tb.sv
`timescale 1ns/1ps
module clkstop_gate_tb;

  localparam int W = 2;
  localparam int S = 2;
  localparam int M = 5;

  logic         clk;
  logic         rst_n;
  logic         stop_n;
  logic         pd_req;
  logic         clk_free;
  logic [W-1:0] clk_grp;

  int n_chk;
  int n_fail;
  int free_bad;
  bit pulse;
  bit shape_bad;

  clkstop_gate #(
    .GROUP_W(W), .SYNC_STAGES(S), .MIN_ON(M)
  ) u_dut (
    .clk_src (clk),
    .rst_n   (rst_n),
    .stop_n  (stop_n),
    .pd_req  (pd_req),
    .clk_free(clk_free),
    .clk_grp (clk_grp)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One source cycle: sample both halves of the high phase and the low phase.
  task automatic cyc();
    logic [W-1:0] a0, a1, a2, a3;
    logic f0, f1, f2, f3;
    @(posedge clk);
    #0.5 a0 = clk_grp; f0 = clk_free;
    #1.0 a1 = clk_grp; f1 = clk_free;
    #1.0 a2 = clk_grp; f2 = clk_free;
    #1.0 a3 = clk_grp; f3 = clk_free;
    pulse = a1[0];
    shape_bad = (a0 != a1) || (a0 != {W{a0[0]}}) || (a2 != '0) || (a3 != '0);
    if (!(f0 && f1 && !f2 && !f3)) free_bad++;
  endtask

  task automatic win(input int cycles, input int drop_at,
                     output int first, output int last, output int cnt,
                     output int contig, output int shape_ok);
    first = -1; last = -1; cnt = 0; contig = 1; shape_ok = 1;
    for (int i = 1; i <= cycles; i++) begin
      cyc();
      if (shape_bad) shape_ok = 0;
      if (pulse) begin
        if (first >= 0 && last != i - 1) contig = 0;
        if (first < 0) first = i;
        last = i;
        cnt++;
      end
      if (i == drop_at) stop_n = 1'b0;
    end
  endtask

  initial begin
    int fi, la, cn, co, sh, exp_cnt, tot;
    n_chk = 0; n_fail = 0; free_bad = 0;
    rst_n = 1'b0; stop_n = 1'b1; pd_req = 1'b0;

    // R11: held low in reset
    win(4, 0, fi, la, cn, co, sh);
    chk("R11 pulses in reset", cn, 0);
    rst_n = 1'b1;
    win(6, 0, fi, la, cn, co, sh);
    chk("R11 first pulse after reset", fi, 3);
    chk("R3 shape after reset", sh, 1);
    stop_n = 1'b0;
    win(15, 0, fi, la, cn, co, sh);
    chk("R2 stopped after reset run", pulse, 0);

    // Sweep of run length before the stop request
    for (int g = 1; g <= M + 2; g++) begin
      exp_cnt = (g + S > M) ? g + S : M;
      stop_n = 1'b1;
      win(S + exp_cnt + 8, S + g, fi, la, cn, co, sh);
      chk("R4 turn-on edge", fi, S + 1);
      if (g + S >= M) chk("R5 pulse count", cn, exp_cnt);
      else            chk("R7 pending stop count", cn, exp_cnt);
      chk("R6 at least MIN_ON", (cn >= M) ? 1 : 0, 1);
      chk("R5 last pulse edge", la, S + exp_cnt);
      chk("R2 contiguous then low", co, 1);
      chk("R3 full high phases", sh, 1);
    end

    // Override inside a fresh hold-off window
    stop_n = 1'b1;
    win(S + 1, 0, fi, la, cn, co, sh);
    chk("R4 restart before override", fi, S + 1);
    pd_req = 1'b1;
    win(10, 0, fi, la, cn, co, sh);
    chk("R8 override pulse count", cn, S);
    chk("R8 override last edge", la, S);
    tot = 0;
    stop_n = 1'b0; win(5, 0, fi, la, cn, co, sh); tot += cn;
    stop_n = 1'b1; win(5, 0, fi, la, cn, co, sh); tot += cn;
    stop_n = 1'b0; win(3, 0, fi, la, cn, co, sh); tot += cn;
    stop_n = 1'b1; win(5, 0, fi, la, cn, co, sh); tot += cn;
    chk("R9 stop ignored under override", tot, 0);
    pd_req = 1'b0;
    win(S + M + 10, S + 1, fi, la, cn, co, sh);
    chk("R10 restart edge", fi, S + 1);
    chk("R10 hold-off reloaded", cn, M);
    chk("R3 shape after override", sh, 1);

    chk("R1 free output never gated", free_bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule